// File: doc/BRIEF.md
# Multi-mode watchdog timer

This block is a watchdog that counts ticks of a slow, free-running watchdog clock enable (`wd_tick`) inside the system clock domain. Software restarts the count with a kick strobe. If the kicks stop, the count reaches the selected period and the watchdog acts. It can raise an interrupt flag, emit a one-cycle system reset pulse, or do both in sequence. In the combined mode, the first expiry gives software a last chance through the interrupt. The next expiry resets the system.

The period is a ladder of powers of two. The shortest rung is `2^BASE_LOG2` ticks, which is 2048 ticks by default and stands for 16 ms of watchdog-clock time. Each step of a 4-bit code doubles the period. Two kinds of write weaken the protection: dropping the reset enable and changing the period. Both are honoured only inside a short window opened by an unlock strobe, so a stray write cannot quietly disarm the reset path.

Top module: `wdog_multimode`

## Requirements
- R1: The count advances only in cycles where `wd_tick` is high, and the period is measured in those ticks, not in system clock cycles.
- R2: The time-out occurs on the `2^(BASE_LOG2+c)`-th tick after the count was last cleared, where `c` is the period code clamped to `MAX_CODE`. The reset value of the code is 0.
- R3: With the interrupt enable set and the reset enable clear, a time-out sets `irq_flag` after the edge that takes the final tick, and `sys_rst_pulse` stays low.
- R4: With the reset enable set and the interrupt enable clear, a time-out drives `sys_rst_pulse` high for exactly one system clock cycle, starting after the edge that takes the final tick.
- R5: With both enables set, a time-out sets `irq_flag`, gives no reset pulse and clears the interrupt enable in hardware. The following time-out then produces the reset pulse of R4. The hardware clear takes priority over a concurrent configuration write.
- R6: `kick` clears the count to zero, and this takes priority over a tick in the same cycle.
- R7: `irq_flag` is cleared by `flag_clr` or by `irq_ack`. A time-out that would set the flag in the same cycle takes priority.
- R8: A write (`cfg_we`) that clears the reset enable or changes the period takes effect only in the 4 cycles after an `unlock` strobe. Any write closes that window. Outside the window, those two fields keep their values, while the interrupt enable and setting the reset enable always take effect.
- R9: After reset both enables are clear, the period code is 0 and both outputs are low. While both enables are clear, the count is held at zero and neither output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_tick | input | 1 | Watchdog clock enable, one pulse per watchdog tick |
| kick | input | 1 | Restart strobe, clears the count |
| unlock | input | 1 | Opens the protected-write window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_period | input | 4 | Period code to write |
| cfg_irq_en | input | 1 | Interrupt enable to write |
| cfg_rst_en | input | 1 | Reset enable to write |
| flag_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq_flag | output | 1 | Interrupt flag |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
Several patterns are used, and each separates a different kind of fault:
- A dense tick stream locates the expiry on the exact tick for codes 0, 1, 2 and a clamped 15. This separates an off-by-one or a wrong ladder step from a correct period.
- A tick on every second cycle shows whether system cycles are being counted instead of ticks.
- Kicks repeated before expiry, and a kick coinciding with a tick, separate a count that is truly cleared from one that only pauses.
- Writes placed on the fourth and on the fifth cycle after an unlock mark the edge of the protection window.
- A long seeded random run mixes ticks, kicks, unlocks, writes and clears against a cycle model. It reaches collisions such as a clear arriving together with an expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef struct packed {
        logic [3:0] period;
        logic       irq_en;
        logic       rst_en;
    } wd_cfg_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_IRQ,
        ACT_RESET,
        ACT_IRQ_ARM
    } wd_act_e;

    function automatic wd_act_e decode_action(input logic irq_en, input logic rst_en);
        case ({irq_en, rst_en})
            2'b10:   return ACT_IRQ;
            2'b01:   return ACT_RESET;
            2'b11:   return ACT_IRQ_ARM;
            default: return ACT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdog_cfg_guard.sv
module wdog_cfg_guard
    import wdog_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    unlock,
    input  logic    cfg_we,
    input  wd_cfg_t wr_cfg,
    input  logic    hw_irq_off,
    output wd_cfg_t cfg,
    output logic    win_open
);
    localparam int WW = $clog2(WINDOW + 1);

    logic [WW-1:0] win_q;
    wd_cfg_t       cfg_d;

    assign win_open = (win_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= '0;
        else if (unlock)
            win_q <= WW'(WINDOW);
        else if (cfg_we || !win_open)
            win_q <= '0;
        else
            win_q <= win_q - 1'b1;
    end

    always_comb begin
        cfg_d = cfg;
        if (cfg_we) begin
            cfg_d.irq_en = wr_cfg.irq_en;
            if (wr_cfg.rst_en)
                cfg_d.rst_en = 1'b1;
            else if (win_open)
                cfg_d.rst_en = 1'b0;
            if (win_open)
                cfg_d.period = wr_cfg.period;
        end
        if (hw_irq_off)
            cfg_d.irq_en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else
            cfg <= cfg_d;
    end
endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9,
    localparam int CW       = BASE_LOG2 + MAX_CODE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          kick,
    input  logic [3:0]    period,
    output logic [CW-1:0] cnt,
    output logic          tmo
);
    logic [3:0]    code_eff;
    logic [CW-1:0] limit_m1;

    assign code_eff = (period > 4'(MAX_CODE)) ? 4'(MAX_CODE) : period;
    assign limit_m1 = (CW'(1) << (BASE_LOG2 + int'(code_eff))) - CW'(1);
    assign tmo      = run && tick && !kick && (cnt >= limit_m1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!run || kick || tmo)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_responder.sv
module wdog_responder
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tmo,
    input  logic irq_en,
    input  logic rst_en,
    input  logic flag_clr,
    input  logic irq_ack,
    output logic irq_flag,
    output logic sys_rst_pulse,
    output logic hw_irq_off
);
    wd_act_e act;

    assign act        = decode_action(irq_en, rst_en);
    assign hw_irq_off = tmo && (act == ACT_IRQ_ARM);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag      <= 1'b0;
            sys_rst_pulse <= 1'b0;
        end else begin
            sys_rst_pulse <= tmo && (act == ACT_RESET);
            if (tmo && (act == ACT_IRQ || act == ACT_IRQ_ARM))
                irq_flag <= 1'b1;
            else if (flag_clr || irq_ack)
                irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_multimode.sv
module wdog_multimode
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9,
    parameter int WINDOW    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_tick,
    input  logic       kick,
    input  logic       unlock,
    input  logic       cfg_we,
    input  logic [3:0] cfg_period,
    input  logic       cfg_irq_en,
    input  logic       cfg_rst_en,
    input  logic       flag_clr,
    input  logic       irq_ack,
    output logic       irq_flag,
    output logic       sys_rst_pulse
);
    localparam int CW = BASE_LOG2 + MAX_CODE;

    wd_cfg_t       wr_cfg;
    wd_cfg_t       cfg_q;
    logic          win_open;
    logic          hw_irq_off;
    logic          tmo;
    logic [CW-1:0] cnt;
    logic          irq_en_q;
    logic          rst_en_q;

    assign wr_cfg   = '{period: cfg_period, irq_en: cfg_irq_en, rst_en: cfg_rst_en};
    assign irq_en_q = cfg_q.irq_en;
    assign rst_en_q = cfg_q.rst_en;

    wdog_cfg_guard #(.WINDOW(WINDOW)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .unlock     (unlock),
        .cfg_we     (cfg_we),
        .wr_cfg     (wr_cfg),
        .hw_irq_off (hw_irq_off),
        .cfg        (cfg_q),
        .win_open   (win_open)
    );

    wdog_tick_counter #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_count (
        .clk    (clk),
        .rst    (rst),
        .run    (irq_en_q || rst_en_q),
        .tick   (wd_tick),
        .kick   (kick),
        .period (cfg_q.period),
        .cnt    (cnt),
        .tmo    (tmo)
    );

    wdog_responder u_resp (
        .clk           (clk),
        .rst           (rst),
        .tmo           (tmo),
        .irq_en        (irq_en_q),
        .rst_en        (rst_en_q),
        .flag_clr      (flag_clr),
        .irq_ack       (irq_ack),
        .irq_flag      (irq_flag),
        .sys_rst_pulse (sys_rst_pulse),
        .hw_irq_off    (hw_irq_off)
    );
endmodule

// File: rtl/wdog_multimode_chk.sv
module wdog_multimode_chk #(
    parameter int CW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          wd_tick,
    input logic          kick,
    input logic          cfg_we,
    input logic          flag_clr,
    input logic          irq_ack,
    input logic          irq_flag,
    input logic          sys_rst_pulse,
    input logic          tmo,
    input logic          irq_en,
    input logic          rst_en,
    input logic          win_open,
    input logic [CW-1:0] cnt
);
    assert_tick_only_R1: assert property (@(posedge clk) disable iff (rst)
        !wd_tick |=> (cnt == $past(cnt) || cnt == '0));

    assert_irq_only_R3: assert property (@(posedge clk) disable iff (rst)
        tmo && irq_en && !rst_en |=> irq_flag && !sys_rst_pulse);

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |=> !sys_rst_pulse);

    assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |-> $past(tmo && rst_en && !irq_en));

    assert_combined_R5: assert property (@(posedge clk) disable iff (rst)
        tmo && irq_en && rst_en |=> irq_flag && !irq_en && !sys_rst_pulse);

    assert_kick_R6: assert property (@(posedge clk) disable iff (rst)
        kick |=> cnt == '0);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr || irq_ack) && !tmo |=> !irq_flag);

    assert_locked_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_we && !win_open && rst_en |=> rst_en);

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_en && !rst_en |=> cnt == '0);
endmodule

bind wdog_multimode wdog_multimode_chk #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wd_tick       (wd_tick),
    .kick          (kick),
    .cfg_we        (cfg_we),
    .flag_clr      (flag_clr),
    .irq_ack       (irq_ack),
    .irq_flag      (irq_flag),
    .sys_rst_pulse (sys_rst_pulse),
    .tmo           (tmo),
    .irq_en        (irq_en_q),
    .rst_en        (rst_en_q),
    .win_open      (win_open),
    .cnt           (cnt)
);

// File: tb/test_wdog_multimode.sv
module test_wdog_multimode;
    localparam int BL = 4;
    localparam int MC = 5;
    localparam int WN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_tick = 1'b0, kick = 1'b0, unlock = 1'b0, cfg_we = 1'b0;
    logic [3:0] cfg_period = '0;
    logic       cfg_irq_en = 1'b0, cfg_rst_en = 1'b0, flag_clr = 1'b0, irq_ack = 1'b0;
    logic       irq_flag, sys_rst_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_per, m_ie, m_re, m_win, m_cnt, m_flag, m_pulse;

    always #10 clk = ~clk;

    wdog_multimode #(.BASE_LOG2(BL), .MAX_CODE(MC), .WINDOW(WN)) i_wdog_multimode (
        .clk(clk), .rst(rst), .wd_tick(wd_tick), .kick(kick), .unlock(unlock),
        .cfg_we(cfg_we), .cfg_period(cfg_period), .cfg_irq_en(cfg_irq_en),
        .cfg_rst_en(cfg_rst_en), .flag_clr(flag_clr), .irq_ack(irq_ack),
        .irq_flag(irq_flag), .sys_rst_pulse(sys_rst_pulse)
    );

    function automatic int limit_of(input int code);
        return 1 << (BL + ((code > MC) ? MC : code));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle model built from the requirements
    always @(posedge clk) begin
        int t, ie_n, re_n, per_n, win_n;
        if (rst) begin
            m_per = 0; m_ie = 0; m_re = 0; m_win = 0; m_cnt = 0; m_flag = 0; m_pulse = 0;
        end else begin
            t = ((m_ie != 0 || m_re != 0) && wd_tick && !kick && m_cnt >= limit_of(m_per) - 1) ? 1 : 0;
            ie_n = m_ie; re_n = m_re; per_n = m_per;
            if (cfg_we) begin
                ie_n = cfg_irq_en;
                if (cfg_rst_en) re_n = 1;
                else if (m_win != 0) re_n = 0;
                if (m_win != 0) per_n = cfg_period;
            end
            if (t != 0 && m_ie != 0 && m_re != 0) ie_n = 0;
            if (unlock) win_n = WN;
            else if (cfg_we || m_win == 0) win_n = 0;
            else win_n = m_win - 1;
            m_pulse = (t != 0 && m_re != 0 && m_ie == 0) ? 1 : 0;
            if (t != 0 && m_ie != 0) m_flag = 1;
            else if (flag_clr || irq_ack) m_flag = 0;
            if ((m_ie == 0 && m_re == 0) || kick || t != 0) m_cnt = 0;
            else if (wd_tick) m_cnt = m_cnt + 1;
            m_ie = ie_n; m_re = re_n; m_per = per_n; m_win = win_n;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("model flag R3 R5 R7", int'(irq_flag), m_flag);
            check("model pulse R4 R5 R8", int'(sys_rst_pulse), m_pulse);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask
    task automatic tk(input int n);
        wd_tick = 1'b1; repeat (n) step(); wd_tick = 1'b0;
    endtask
    task automatic wr(input int p, input bit ie, input bit re);
        cfg_we = 1'b1; cfg_period = 4'(p); cfg_irq_en = ie; cfg_rst_en = re;
        step(); cfg_we = 1'b0;
    endtask
    task automatic unl();
        unlock = 1'b1; step(); unlock = 1'b0;
    endtask
    task automatic kk();
        kick = 1'b1; step(); kick = 1'b0;
    endtask
    task automatic clr();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        rst = 1'b0;
        step();
        // R9 reset state and idle
        check("R9 flag after reset", int'(irq_flag), 0);
        check("R9 pulse after reset", int'(sys_rst_pulse), 0);
        tk(40);
        check("R9 idle no flag", int'(irq_flag), 0);
        check("R9 idle no pulse", int'(sys_rst_pulse), 0);

        // R3 interrupt only, R2 base period
        wr(0, 1, 0); kk();
        tk(15); check("R2 no expiry at 15 ticks", int'(irq_flag), 0);
        tk(1);  check("R3 flag at 16 ticks", int'(irq_flag), 1);
        check("R3 no pulse", int'(sys_rst_pulse), 0);
        clr();  check("R7 flag_clr", int'(irq_flag), 0);

        // R1 sparse ticks
        kk();
        repeat (15) begin tk(1); step(); end
        check("R1 fifteen ticks over thirty cycles", int'(irq_flag), 0);
        tk(1); check("R1 sixteenth tick", int'(irq_flag), 1);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        check("R7 irq_ack", int'(irq_flag), 0);

        // R6 kicks
        kk();
        repeat (6) begin tk(12); kk(); end
        check("R6 kicked never expires", int'(irq_flag), 0);
        tk(15);
        wd_tick = 1'b1; kick = 1'b1; step(); wd_tick = 1'b0; kick = 1'b0;
        tk(15); check("R6 kick beats tick", int'(irq_flag), 0);
        tk(1);  check("R6 expiry after kick", int'(irq_flag), 1);
        clr();

        // R4 reset only
        wr(0, 0, 1); kk();
        tk(15); check("R4 no pulse at 15", int'(sys_rst_pulse), 0);
        tk(1);  check("R4 pulse high", int'(sys_rst_pulse), 1);
        check("R4 no flag", int'(irq_flag), 0);
        step(); check("R4 pulse one cycle", int'(sys_rst_pulse), 0);

        // R5 combined
        wr(0, 1, 1); kk();
        tk(16); check("R5 first expiry flag", int'(irq_flag), 1);
        check("R5 first expiry no pulse", int'(sys_rst_pulse), 0);
        clr();
        tk(15); check("R5 no early pulse", int'(sys_rst_pulse), 0);
        tk(1);  check("R5 second expiry pulse", int'(sys_rst_pulse), 1);

        // R8 locked write
        wr(1, 0, 0); kk();
        tk(16); check("R8 locked clear ignored", int'(sys_rst_pulse), 1);
        unl(); step(); step(); step();
        wr(1, 0, 0);
        wr(1, 1, 0); kk();
        tk(31); check("R8 fourth-cycle write period", int'(irq_flag), 0);
        tk(1);  check("R8 fourth-cycle write accepted", int'(irq_flag), 1);
        check("R8 reset cleared", int'(sys_rst_pulse), 0);
        clr();
        wr(1, 0, 1);
        unl(); repeat (4) step();
        wr(0, 0, 0); kk();
        tk(16); check("R8 fifth-cycle period kept", int'(sys_rst_pulse), 0);
        tk(16); check("R8 fifth-cycle write ignored", int'(sys_rst_pulse), 1);
        unl(); wr(1, 0, 1); wr(0, 0, 0); kk();
        tk(32); check("R8 window closed by write", int'(sys_rst_pulse), 1);

        // R2 ladder and clamp
        unl(); wr(2, 1, 0); kk();
        tk(63); check("R2 code 2 early", int'(irq_flag), 0);
        tk(1);  check("R2 code 2 at 64", int'(irq_flag), 1);
        clr();
        unl(); wr(15, 1, 0); kk();
        tk(511); check("R2 clamp early", int'(irq_flag), 0);
        tk(1);   check("R2 clamp at 512", int'(irq_flag), 1);
        clr();

        // seeded random mix against the model
        for (int i = 0; i < 20000; i++) begin
            wd_tick    = 1'($urandom_range(0, 1));
            kick       = ($urandom_range(0, 39) == 0);
            unlock     = ($urandom_range(0, 24) == 0);
            cfg_we     = ($urandom_range(0, 14) == 0);
            cfg_period = ($urandom_range(0, 9) == 0) ? 4'd15 : 4'($urandom_range(0, 2));
            cfg_irq_en = 1'($urandom_range(0, 1));
            cfg_rst_en = 1'($urandom_range(0, 1));
            flag_clr   = ($urandom_range(0, 29) == 0);
            irq_ack    = ($urandom_range(0, 29) == 0);
            step();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule